// File: doc/BRIEF.md
# PWM Parameter Load Controller

This block is the control-register path of one pulse-width output channel. A single 32-bit value word is shared by every timing parameter: a 4-bit request code selects which parameter the word updates. These are the period, the on-delay, the dither ramp times, the dither amplitude and the dither period. New values first go into shadow registers. They reach the active registers, which feed the waveform generator, only on the one-cycle pulse that marks the end of a PWM period. A new setting therefore never cuts a period short.

The mode bit selects how the word is taken. In one-shot mode it is taken once, on a control write strobe. In cyclic mode it is taken again on every clock. An unknown request code is reported differently in each mode. In one-shot mode it sets a sticky load error. In cyclic mode it sets a level flag that follows the current code. The block also latches three external fault indications and clears them on request. It gates the output run state with a software enable and an optional hardware enable. It chooses whether the two outputs follow the PWM sequence or are driven directly.

Top module: `pwm_param_loader`

## Requirements
- R1: Request code 1 loads the whole value into the period. Code 2 loads the on-delay. Code 5 loads bits [15:0] into ramp-up and bits [31:16] into ramp-down. Code 6 loads bits [7:0] into the amplitude. Code 7 loads the dither period. Code 0 changes nothing and raises no error.
- R2: With `cyclic_i` at 0, a value is taken only on a clock edge where `ctrl_wr_i` is 1. With `ctrl_wr_i` at 0, the code and value have no effect.
- R3: With `cyclic_i` at 1, the value is taken on every clock edge whether or not `ctrl_wr_i` is set. The last value taken before the period-end pulse is the one applied.
- R4: A taken value appears on the parameter outputs only after a clock edge where `period_end_i` is 1. Until then the outputs keep their previous value.
- R5: Reset returns the shadow and active parameter registers to the parameter defaults. A period-end pulse right after reset keeps the defaults.
- R6: A code other than 0, 1, 2, 5, 6 or 7, written in one-shot mode, sets `err_ld_o` from the next cycle and changes no parameter. The flag stays set until an edge with `err_clr_i` at 1.
- R7: In cyclic mode, `err_slot_o` is 1 in the cycle after an invalid code is presented. It returns to 0 in the cycle after a valid code is presented or cyclic mode is left. `err_clr_i` does not act on it.
- R8: `run_o` is `sw_en_i` AND (`hw_en_i` when `hw_en_sel_i` is 1, otherwise 1).
- R9: With `tech_ctrl_i` at 1, `out_a_o` equals `pwm_seq_i` AND `run_o`, and `out_b_o` is 0.
- R10: With `tech_ctrl_i` at 0, `out_a_o` is `set_a_i` AND NOT `set_b_i`, and `out_b_o` is `set_b_i` AND NOT `set_a_i`. When both set inputs are 1, both outputs are 0.
- R11: `err_24v_o`, `err_a_o` and `err_b_o` latch a 1 from their fault inputs and clear on an edge with `err_clr_i` at 1. On an edge where a fault and the clear are both present, the fault wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| value_i | input | 32 | Shared parameter value word |
| req_code_i | input | 4 | Load request code |
| cyclic_i | input | 1 | 1: take value every cycle, 0: one-shot |
| ctrl_wr_i | input | 1 | Control write strobe (one-shot mode) |
| period_end_i | input | 1 | End-of-period pulse; transfers shadows to active |
| sw_en_i | input | 1 | Software enable |
| hw_en_sel_i | input | 1 | Selects use of the hardware enable |
| hw_en_i | input | 1 | External hardware enable |
| tech_ctrl_i | input | 1 | 1: outputs follow PWM sequence |
| set_a_i | input | 1 | Direct level for output A |
| set_b_i | input | 1 | Direct level for output B |
| pwm_seq_i | input | 1 | PWM sequence from the generator |
| err_clr_i | input | 1 | Clears latched errors |
| fault_24v_i | input | 1 | Supply fault indication |
| fault_a_i | input | 1 | Output A fault indication |
| fault_b_i | input | 1 | Output B fault indication |
| period_o | output | 32 | Active period (us) |
| on_delay_o | output | 32 | Active on-delay (us) |
| ramp_up_o | output | 16 | Active dither ramp-up (ms) |
| ramp_down_o | output | 16 | Active dither ramp-down (ms) |
| amp_o | output | 8 | Active dither amplitude (%) |
| dith_period_o | output | 32 | Active dither period (us) |
| err_ld_o | output | 1 | Sticky one-shot load error |
| err_slot_o | output | 1 | Cyclic-mode invalid code flag |
| err_24v_o | output | 1 | Latched supply fault |
| err_a_o | output | 1 | Latched output A fault |
| err_b_o | output | 1 | Latched output B fault |
| run_o | output | 1 | Combined enable |
| out_a_o | output | 1 | Output A |
| out_b_o | output | 1 | Output B |

## Verification
The hardest case to reach from the ports is cyclic mode. There the shadow is overwritten on every cycle, so the bench has to show that only the last value before the period-end pulse survives. The stimulus changes the value over several consecutive cycles with the strobe held low. It then leaves cyclic mode and pulses the period end, so that an intermediate value would show on `period_o`. The same sequence starts from an invalid code, which checks that the level error flag drops one cycle after the first valid code.

// File: rtl/pwm_param_loader.sv
module pwm_param_loader #(
  parameter int VAL_W = 32,
  parameter int AMP_W = 8,
  parameter logic [VAL_W-1:0] DEF_PERIOD = 32'd1000,
  parameter logic [VAL_W-1:0] DEF_ONDLY  = 32'd0,
  parameter logic [VAL_W/2-1:0] DEF_RUP  = 16'd10,
  parameter logic [VAL_W/2-1:0] DEF_RDN  = 16'd10,
  parameter logic [AMP_W-1:0] DEF_AMP    = 8'd5,
  parameter logic [VAL_W-1:0] DEF_DPER   = 32'd100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VAL_W-1:0]   value_i,
  input  logic [3:0]         req_code_i,
  input  logic               cyclic_i,
  input  logic               ctrl_wr_i,
  input  logic               period_end_i,
  input  logic               sw_en_i,
  input  logic               hw_en_sel_i,
  input  logic               hw_en_i,
  input  logic               tech_ctrl_i,
  input  logic               set_a_i,
  input  logic               set_b_i,
  input  logic               pwm_seq_i,
  input  logic               err_clr_i,
  input  logic               fault_24v_i,
  input  logic               fault_a_i,
  input  logic               fault_b_i,
  output logic [VAL_W-1:0]   period_o,
  output logic [VAL_W-1:0]   on_delay_o,
  output logic [VAL_W/2-1:0] ramp_up_o,
  output logic [VAL_W/2-1:0] ramp_down_o,
  output logic [AMP_W-1:0]   amp_o,
  output logic [VAL_W-1:0]   dith_period_o,
  output logic               err_ld_o,
  output logic               err_slot_o,
  output logic               err_24v_o,
  output logic               err_a_o,
  output logic               err_b_o,
  output logic               run_o,
  output logic               out_a_o,
  output logic               out_b_o
);
  localparam int HALF = VAL_W / 2;

  logic [VAL_W-1:0] sh_period, sh_ondly, sh_dper;
  logic [HALF-1:0]  sh_rup, sh_rdn;
  logic [AMP_W-1:0] sh_amp;
  logic             code_ok;

  always_comb begin
    case (req_code_i)
      4'd0, 4'd1, 4'd2, 4'd5, 4'd6, 4'd7: code_ok = 1'b1;
      default:                            code_ok = 1'b0;
    endcase
  end

  wire take   = cyclic_i | ctrl_wr_i;
  wire accept = take & code_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_period <= DEF_PERIOD;
      sh_ondly  <= DEF_ONDLY;
      sh_rup    <= DEF_RUP;
      sh_rdn    <= DEF_RDN;
      sh_amp    <= DEF_AMP;
      sh_dper   <= DEF_DPER;
    end else if (accept) begin
      case (req_code_i)
        4'd1: sh_period <= value_i;
        4'd2: sh_ondly  <= value_i;
        4'd5: begin
          sh_rup <= value_i[HALF-1:0];
          sh_rdn <= value_i[VAL_W-1:HALF];
        end
        4'd6: sh_amp    <= value_i[AMP_W-1:0];
        4'd7: sh_dper   <= value_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_o      <= DEF_PERIOD;
      on_delay_o    <= DEF_ONDLY;
      ramp_up_o     <= DEF_RUP;
      ramp_down_o   <= DEF_RDN;
      amp_o         <= DEF_AMP;
      dith_period_o <= DEF_DPER;
    end else if (period_end_i) begin
      period_o      <= sh_period;
      on_delay_o    <= sh_ondly;
      ramp_up_o     <= sh_rup;
      ramp_down_o   <= sh_rdn;
      amp_o         <= sh_amp;
      dith_period_o <= sh_dper;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_ld_o   <= 1'b0;
      err_slot_o <= 1'b0;
      err_24v_o  <= 1'b0;
      err_a_o    <= 1'b0;
      err_b_o    <= 1'b0;
    end else begin
      err_slot_o <= cyclic_i & ~code_ok;
      if (ctrl_wr_i & ~cyclic_i & ~code_ok) err_ld_o <= 1'b1;
      else if (err_clr_i)                   err_ld_o <= 1'b0;
      err_24v_o <= fault_24v_i | (err_24v_o & ~err_clr_i);
      err_a_o   <= fault_a_i   | (err_a_o   & ~err_clr_i);
      err_b_o   <= fault_b_i   | (err_b_o   & ~err_clr_i);
    end
  end

  assign run_o   = sw_en_i & (~hw_en_sel_i | hw_en_i);
  assign out_a_o = tech_ctrl_i ? (pwm_seq_i & run_o) : (set_a_i & ~set_b_i);
  assign out_b_o = ~tech_ctrl_i & set_b_i & ~set_a_i;
endmodule

// File: rtl/pwm_param_loader_chk.sv
module pwm_param_loader_chk #(
  parameter int VAL_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       req_code_i,
  input logic             cyclic_i,
  input logic             ctrl_wr_i,
  input logic             period_end_i,
  input logic             sw_en_i,
  input logic             tech_ctrl_i,
  input logic             err_clr_i,
  input logic [VAL_W-1:0] period_o,
  input logic             err_ld_o,
  input logic             err_slot_o,
  input logic             run_o,
  input logic             out_a_o,
  input logic             out_b_o
);
  logic bad_code;
  always_comb begin
    case (req_code_i)
      4'd0, 4'd1, 4'd2, 4'd5, 4'd6, 4'd7: bad_code = 1'b0;
      default:                            bad_code = 1'b1;
    endcase
  end

  p_hold_until_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end_i |=> $stable(period_o));

  p_ld_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && !cyclic_i && bad_code) |=> err_ld_o);

  p_ld_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ld_o && !err_clr_i) |=> err_ld_o);

  p_slot_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyclic_i && bad_code) |=> err_slot_o);

  p_slot_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyclic_i || !bad_code) |=> !err_slot_o);

  p_no_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en_i |-> !run_o);

  p_b_low_tech_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tech_ctrl_i |-> !out_b_o);

  p_excl_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a_o && out_b_o));
endmodule

bind pwm_param_loader pwm_param_loader_chk #(.VAL_W(VAL_W)) u_chk (.*);

// File: tb/pwm_param_loader_tb_top.sv
module pwm_param_loader_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] value_i = '0;
  logic [3:0]  req_code_i = '0;
  logic cyclic_i = 0, ctrl_wr_i = 0, period_end_i = 0, sw_en_i = 0, hw_en_sel_i = 0;
  logic hw_en_i = 0, tech_ctrl_i = 0, set_a_i = 0, set_b_i = 0, pwm_seq_i = 0;
  logic err_clr_i = 0, fault_24v_i = 0, fault_a_i = 0, fault_b_i = 0;
  logic [31:0] period_o, on_delay_o, dith_period_o;
  logic [15:0] ramp_up_o, ramp_down_o;
  logic [7:0]  amp_o;
  logic err_ld_o, err_slot_o, err_24v_o, err_a_o, err_b_o, run_o, out_a_o, out_b_o;

  pwm_param_loader dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_once(logic [3:0] c, logic [31:0] v);
    req_code_i = c; value_i = v; ctrl_wr_i = 1; step();
    ctrl_wr_i = 0; period_end_i = 1; step();
    period_end_i = 0;
  endtask

  localparam int NV = 6;
  localparam logic [3:0]  V_CODE [NV] = '{4'd1, 4'd2, 4'd5, 4'd6, 4'd7, 4'd0};
  localparam logic [31:0] V_VAL  [NV] = '{32'd10000, 32'd100, 32'h0014_0032,
                                          32'h0000_0123, 32'd500, 32'hFFFF_FFFF};
  localparam logic [31:0] E_PER  [NV] = '{32'd10000, 32'd10000, 32'd10000, 32'd10000, 32'd10000, 32'd10000};
  localparam logic [31:0] E_OND  [NV] = '{32'd0, 32'd100, 32'd100, 32'd100, 32'd100, 32'd100};
  localparam logic [15:0] E_RUP  [NV] = '{16'd10, 16'd10, 16'd50, 16'd50, 16'd50, 16'd50};
  localparam logic [15:0] E_RDN  [NV] = '{16'd10, 16'd10, 16'd20, 16'd20, 16'd20, 16'd20};
  localparam logic [7:0]  E_AMP  [NV] = '{8'd5, 8'd5, 8'd5, 8'h23, 8'h23, 8'h23};
  localparam logic [31:0] E_DPER [NV] = '{32'd100, 32'd100, 32'd100, 32'd100, 32'd500, 32'd500};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(); rst_n = 1; step();
    // R5: reset state
    check("R5 period", period_o, 32'd1000);
    check("R5 amp", {24'd0, amp_o}, 32'd5);
    check("R6 err_ld reset", {31'd0, err_ld_o}, 0);

    // R4: staged value not visible before period end
    req_code_i = 4'd1; value_i = 32'd4242; ctrl_wr_i = 1; step(); ctrl_wr_i = 0; step();
    check("R4 before end", period_o, 32'd1000);
    period_end_i = 1; step(); period_end_i = 0;
    check("R4 after end", period_o, 32'd4242);

    // R1: decode table
    for (int i = 0; i < NV; i++) begin
      load_once(V_CODE[i], V_VAL[i]);
      check("R1 period", period_o, E_PER[i]);
      check("R1 on_delay", on_delay_o, E_OND[i]);
      check("R1 ramp_up", {16'd0, ramp_up_o}, {16'd0, E_RUP[i]});
      check("R1 ramp_down", {16'd0, ramp_down_o}, {16'd0, E_RDN[i]});
      check("R1 amp", {24'd0, amp_o}, {24'd0, E_AMP[i]});
      check("R1 dith_period", dith_period_o, E_DPER[i]);
      check("R1 no err", {31'd0, err_ld_o}, 0);
    end

    // R2: no strobe, one-shot mode: ignored
    req_code_i = 4'd1; value_i = 32'd1; step();
    period_end_i = 1; step(); period_end_i = 0;
    check("R2 no strobe", period_o, 32'd10000);

    // R7 + R3: cyclic mode, invalid then changing valid values
    cyclic_i = 1; req_code_i = 4'd9; step();
    check("R7 slot set", {31'd0, err_slot_o}, 1);
    check("R7 no ld err", {31'd0, err_ld_o}, 0);
    err_clr_i = 1; step(); err_clr_i = 0;
    check("R7 clr no effect", {31'd0, err_slot_o}, 1);
    req_code_i = 4'd1; value_i = 32'd777; step();
    check("R7 slot drop", {31'd0, err_slot_o}, 0);
    value_i = 32'd888; step();
    cyclic_i = 0; req_code_i = 4'd0; period_end_i = 1; step(); period_end_i = 0;
    check("R3 last value", period_o, 32'd888);
    cyclic_i = 1; req_code_i = 4'd12; step(); cyclic_i = 0; step();
    check("R7 leave cyclic", {31'd0, err_slot_o}, 0);

    // R6: invalid one-shot
    req_code_i = 4'd3; value_i = 32'd5; ctrl_wr_i = 1; step(); ctrl_wr_i = 0;
    check("R6 set", {31'd0, err_ld_o}, 1);
    period_end_i = 1; step(); period_end_i = 0;
    check("R6 no change", period_o, 32'd888);
    req_code_i = 4'd1; value_i = 32'd55; ctrl_wr_i = 1; step(); ctrl_wr_i = 0; step();
    check("R6 sticky", {31'd0, err_ld_o}, 1);
    err_clr_i = 1; step(); err_clr_i = 0;
    check("R6 cleared", {31'd0, err_ld_o}, 0);

    // R11: fault latches
    fault_24v_i = 1; fault_b_i = 1; step(); fault_24v_i = 0; fault_b_i = 0; step();
    check("R11 24v latch", {31'd0, err_24v_o}, 1);
    check("R11 b latch", {31'd0, err_b_o}, 1);
    err_clr_i = 1; fault_a_i = 1; step(); err_clr_i = 0; fault_a_i = 0;
    check("R11 24v cleared", {31'd0, err_24v_o}, 0);
    check("R11 set wins", {31'd0, err_a_o}, 1);

    // R8: enable gating
    sw_en_i = 1; hw_en_sel_i = 0; hw_en_i = 0; #1;
    check("R8 sw only", {31'd0, run_o}, 1);
    hw_en_sel_i = 1; #1;
    check("R8 hw low", {31'd0, run_o}, 0);
    hw_en_i = 1; #1;
    check("R8 both", {31'd0, run_o}, 1);
    sw_en_i = 0; #1;
    check("R8 sw low", {31'd0, run_o}, 0);

    // R9: technology drive
    tech_ctrl_i = 1; sw_en_i = 1; pwm_seq_i = 1; set_b_i = 1; #1;
    check("R9 a follows", {31'd0, out_a_o}, 1);
    check("R9 b zero", {31'd0, out_b_o}, 0);
    sw_en_i = 0; #1;
    check("R9 gated", {31'd0, out_a_o}, 0);

    // R10: direct drive
    tech_ctrl_i = 0; set_a_i = 1; set_b_i = 0; #1;
    check("R10 a only", {30'd0, out_a_o, out_b_o}, 32'b10);
    set_a_i = 0; set_b_i = 1; #1;
    check("R10 b only", {30'd0, out_a_o, out_b_o}, 32'b01);
    set_a_i = 1; #1;
    check("R10 both set", {30'd0, out_a_o, out_b_o}, 32'b00);
    step();

    // R5: reset restores defaults, shadows included
    rst_n = 0; step(); rst_n = 1; step();
    period_end_i = 1; step(); period_end_i = 0;
    check("R5 period after reset", period_o, 32'd1000);
    check("R5 dith_period after reset", dith_period_o, 32'd100);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule